// File: doc/BRIEF.md
# Two-Wire Transfer Sequencer

This block runs a chain of two-wire bus transfers without software help. Each transfer is a descriptor: a 7-bit or 10-bit target address, a direction and a byte count. The block queues descriptors in a small FIFO. It then drives the control and data registers of a byte-level two-wire controller, one action for each interrupt event the controller raises. It picks the action from the status code the controller reports together with that event, and it counts the bytes of the current transfer.

Bytes to write come in on a valid/ready stream. Bytes that are received leave on a valid-only stream. Messages in a chain are joined by repeated starts, and a STOP goes out only after the last one. The block ends a chain in one of three ways: a completion pulse, a missing-target error or a bus error. Any end of a chain discards the descriptors that were not used. An optional guard interval can be enabled. It spaces a repeated start after the decision that calls for it, and it holds back completion after the final STOP.

Control bytes written to the controller use these bit positions: bit 2 acknowledge-enable, bit 4 STOP, bit 5 START, bit 6 bus enable, bit 7 interrupt enable. The running value is 0xC4.

Top module: `twi_xfer_seq`

## Requirements
- R1: When `go` is pulsed while the block is idle and at least one descriptor is queued, the next cycle carries a control write of 0xE4 (START plus the running bits), and `busy` rises.
- R2: On status 0x08 or 0x10, the block writes the first address byte to the data register. For 7-bit addressing this byte is {addr[6:0], rd}, with rd = 1 for a read. The same cycle carries a control write of the running bits.
- R3: For 10-bit addressing, the first byte is {5'b11110, addr[9:8], rd}. On status 0x18 or 0x40, the block then writes the second byte, addr[7:0].
- R4: On a write acknowledge (0x18 for 7-bit, 0xD0, 0x28) with bytes still left, the block writes the next stream byte to the data register and takes it. If the stream has no byte ready, the data write waits until one arrives.
- R5: When a write message has no bytes left and it is the last message, the block writes a STOP control byte with interrupt enable cleared (0x54), then completes.
- R6: When a write message has no bytes left and more messages follow, the block loads the next descriptor and writes 0xE4 (a repeated start) after the guard delay. No STOP is written in this case.
- R7: On a read address acknowledge (0x40 for 7-bit, 0xE0), a zero-length read issues STOP and completes. Otherwise the block writes control with acknowledge-enable set while more than one byte is left. The value is 0xC0 (acknowledge-enable cleared) once exactly one byte is left.
- R8: Status 0x50 puts the data register byte on the read stream. Status 0x58 does the same, then writes STOP with interrupt enable cleared and completes.
- R9: Status 0x20, 0x30 or 0x48 writes STOP and pulses `err_nodev`, with no completion.
- R10: Any other status writes STOP, pulses the controller reset and pulses `err_bus`.
- R11: An interrupt event while the block is idle gets only a STOP control write. It raises no error, and queued descriptors stay for the next `go`.
- R12: Completion arrives GUARD delay cycles after the final STOP write. That delay is GUARD_CYC when the guard is enabled and 1 otherwise. `go` has no effect while `busy` is high.
- R13: Completion and both errors flush the unused descriptors, so a later `go` with no new descriptor does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor push request |
| desc_ready | output | 1 | Descriptor FIFO has room |
| desc_addr | input | 10 | Target address |
| desc_rd | input | 1 | 1 = read message |
| desc_ten | input | 1 | 1 = 10-bit addressing |
| desc_len | input | LEN_W | Byte count |
| go | input | 1 | Start the queued chain |
| busy | output | 1 | Chain in progress or guard running |
| irq | input | 1 | One-cycle controller event |
| status | input | 8 | Controller status code, valid with irq |
| rd_reg | input | 8 | Controller data register contents, valid with irq |
| ctl_wr | output | 1 | Control register write strobe |
| ctl_data | output | 8 | Control register value |
| dat_wr | output | 1 | Data register write strobe |
| dat_data | output | 8 | Data register value |
| ctl_reset | output | 1 | Controller reset pulse |
| wr_valid | input | 1 | Write stream byte available |
| wr_data | input | 8 | Write stream byte |
| wr_ready | output | 1 | Write stream byte taken this cycle |
| rd_valid | output | 1 | Read stream byte valid |
| rd_data | output | 8 | Read stream byte |
| done | output | 1 | Chain completed |
| err_nodev | output | 1 | Target did not acknowledge |
| err_bus | output | 1 | Unexpected status code |

## Verification
Every register write, stream byte and error flag is registered. Each one appears one cycle after the `irq` or `go` cycle that causes it, so the bench drives stimulus on a falling edge and checks the outputs on the next falling edge. A repeated start appears GUARD_CYC cycles after its deciding event, and `done` appears GUARD_CYC cycles after the final STOP. The bench counts falling edges from the STOP or the deciding event and compares the count with the configured delay of 5. A write that stalls on an empty stream is checked across idle cycles, and the data write is expected one cycle after `wr_valid` rises.

// File: rtl/twi_seq_pkg.sv
package twi_seq_pkg;

   localparam logic [7:0] CB_ACK   = 8'h04;
   localparam logic [7:0] CB_STOP  = 8'h10;
   localparam logic [7:0] CB_START = 8'h20;
   localparam logic [7:0] CB_EN    = 8'h40;
   localparam logic [7:0] CB_IEN   = 8'h80;
   localparam logic [7:0] CB_RUN   = CB_ACK | CB_EN | CB_IEN;

   localparam logic [7:0] SC_START    = 8'h08;
   localparam logic [7:0] SC_RSTART   = 8'h10;
   localparam logic [7:0] SC_WA_ACK   = 8'h18;
   localparam logic [7:0] SC_WA_NACK  = 8'h20;
   localparam logic [7:0] SC_WD_ACK   = 8'h28;
   localparam logic [7:0] SC_WD_NACK  = 8'h30;
   localparam logic [7:0] SC_RA_ACK   = 8'h40;
   localparam logic [7:0] SC_RA_NACK  = 8'h48;
   localparam logic [7:0] SC_RD_ACK   = 8'h50;
   localparam logic [7:0] SC_RD_NACK  = 8'h58;
   localparam logic [7:0] SC_WA2_ACK  = 8'hD0;
   localparam logic [7:0] SC_RA2_ACK  = 8'hE0;

   typedef enum logic [2:0] {
      PH_IDLE, PH_START, PH_RESTART, PH_ADR1, PH_ADR2, PH_WACK, PH_RDAT
   } phase_t;

   typedef enum logic [3:0] {
      A_NONE, A_BEGIN, A_RESTART, A_RSTART, A_ADDR1, A_ADDR2, A_SEND,
      A_HOLD, A_CONT, A_RECV, A_RECV_STOP, A_FINISH, A_NODEV, A_BUSERR,
      A_STRAY
   } act_t;

   function automatic logic [7:0] lead_byte(input logic [9:0] a,
                                            input logic ten,
                                            input logic rd);
      return ten ? {5'b11110, a[9:8], rd} : {a[6:0], rd};
   endfunction

endpackage

// File: rtl/twi_desc_fifo.sv
module twi_desc_fifo #(
   parameter int W     = 20,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   output logic          full,
   input  logic          pop,
   input  logic          flush,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic [CW-1:0] count
);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          do_push;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign dout    = mem[rp];

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= bump(wp);
         if (flush) begin
            rp    <= wp;
            count <= do_push ? CW'(1) : '0;
         end else begin
            if (pop && !empty) rp <= bump(rp);
            count <= count + CW'(do_push) - CW'(pop && !empty);
         end
      end
   end

   assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   assert_flush_empties_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !push) |=> empty);

endmodule

// File: rtl/twi_guard_timer.sv
module twi_guard_timer #(
   parameter int N = 1,
   localparam int CW = $clog2(N + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic fire
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= CW'(N);
      else if (cnt != '0)  cnt <= cnt - CW'(1);
   end

   assign fire = (cnt == CW'(1));

   assert_guard_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (cnt == '0));
   assert_fire_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

endmodule

// File: rtl/twi_xfer_seq.sv
module twi_xfer_seq
   import twi_seq_pkg::*;
#(
   parameter int LEN_W      = 8,
   parameter int DESC_DEPTH = 4,
   parameter bit GUARD_EN   = 1'b0,
   parameter int GUARD_CYC  = 625
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             desc_valid,
   output logic             desc_ready,
   input  logic [9:0]       desc_addr,
   input  logic             desc_rd,
   input  logic             desc_ten,
   input  logic [LEN_W-1:0] desc_len,
   input  logic             go,
   output logic             busy,
   input  logic             irq,
   input  logic [7:0]       status,
   input  logic [7:0]       rd_reg,
   output logic             ctl_wr,
   output logic [7:0]       ctl_data,
   output logic             dat_wr,
   output logic [7:0]       dat_data,
   output logic             ctl_reset,
   input  logic             wr_valid,
   input  logic [7:0]       wr_data,
   output logic             wr_ready,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic             err_nodev,
   output logic             err_bus
);

   localparam int DW = 12 + LEN_W;
   localparam int FCW = $clog2(DESC_DEPTH + 1);

   if (DESC_DEPTH < 2) begin : g_bad_depth
      $error("DESC_DEPTH must be at least 2");
   end
   if (GUARD_CYC < 1) begin : g_bad_guard
      $error("GUARD_CYC must be at least 1");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("LEN_W must be at least 2");
   end

   // descriptor queue
   logic [DW-1:0]  q_head;
   logic           q_full, q_empty, q_pop, q_flush;
   logic [FCW-1:0] q_count;

   twi_desc_fifo #(.W(DW), .DEPTH(DESC_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(desc_valid), .din({desc_addr, desc_rd, desc_ten, desc_len}),
      .full(q_full), .pop(q_pop), .flush(q_flush),
      .dout(q_head), .empty(q_empty), .count(q_count)
   );
   assign desc_ready = !q_full;

   // guard interval
   logic g_load, g_fire;

   if (GUARD_EN) begin : g_guard_on
      twi_guard_timer #(.N(GUARD_CYC)) u_guard (
         .clk(clk), .rst_n(rst_n), .load(g_load), .fire(g_fire));
   end else begin : g_guard_off
      twi_guard_timer #(.N(1)) u_guard (
         .clk(clk), .rst_n(rst_n), .load(g_load), .fire(g_fire));
   end

   // transfer context
   phase_t           phase;
   logic [9:0]       c_addr;
   logic             c_rd, c_ten, c_last;
   logic [LEN_W-1:0] left;
   logic [7:0]       cbits;
   logic             rs_pend, fin_pend, tx_pend;

   act_t act, nxt_wr, nxt_rd;

   always_comb begin
      if (left == '0)   nxt_wr = c_last ? A_FINISH : A_RESTART;
      else if (wr_valid) nxt_wr = A_SEND;
      else              nxt_wr = A_HOLD;
      nxt_rd = (left == '0) ? A_FINISH : A_CONT;

      act = A_NONE;
      if (phase == PH_IDLE) begin
         if (irq)                              act = A_STRAY;
         else if (go && !fin_pend && !q_empty) act = A_BEGIN;
      end else if (tx_pend) begin
         act = wr_valid ? A_SEND : A_NONE;
      end else if (rs_pend) begin
         act = g_fire ? A_RSTART : A_NONE;
      end else if (irq) begin
         case (status)
            SC_START, SC_RSTART:              act = A_ADDR1;
            SC_WA_ACK:                        act = c_ten ? A_ADDR2 : nxt_wr;
            SC_WA2_ACK, SC_WD_ACK:            act = nxt_wr;
            SC_RA_ACK:                        act = c_ten ? A_ADDR2 : nxt_rd;
            SC_RA2_ACK:                       act = nxt_rd;
            SC_RD_ACK:                        act = A_RECV;
            SC_RD_NACK:                       act = A_RECV_STOP;
            SC_WA_NACK, SC_WD_NACK, SC_RA_NACK: act = A_NODEV;
            default:                          act = A_BUSERR;
         endcase
      end
   end

   assign q_pop    = (act == A_BEGIN) || (act == A_RESTART);
   assign q_flush  = act inside {A_FINISH, A_RECV_STOP, A_NODEV, A_BUSERR};
   assign g_load   = act inside {A_RESTART, A_FINISH, A_RECV_STOP};
   assign wr_ready = (act == A_SEND);
   assign busy     = (phase != PH_IDLE) || fin_pend;

   logic [7:0] stop_bits;
   assign stop_bits = (cbits & ~CB_IEN) | CB_STOP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         c_addr    <= '0;
         c_rd      <= 1'b0;
         c_ten     <= 1'b0;
         c_last    <= 1'b0;
         left      <= '0;
         cbits     <= CB_RUN;
         rs_pend   <= 1'b0;
         fin_pend  <= 1'b0;
         tx_pend   <= 1'b0;
         ctl_wr    <= 1'b0;
         ctl_data  <= '0;
         dat_wr    <= 1'b0;
         dat_data  <= '0;
         ctl_reset <= 1'b0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         done      <= 1'b0;
         err_nodev <= 1'b0;
         err_bus   <= 1'b0;
      end else begin
         ctl_wr    <= 1'b0;
         dat_wr    <= 1'b0;
         ctl_reset <= 1'b0;
         rd_valid  <= 1'b0;
         done      <= 1'b0;
         err_nodev <= 1'b0;
         err_bus   <= 1'b0;

         if (fin_pend && g_fire) begin
            fin_pend <= 1'b0;
            done     <= 1'b0 | 1'b1;
         end

         case (act)
            A_BEGIN, A_RESTART: begin
               {c_addr, c_rd, c_ten, left} <= q_head;
               c_last <= (q_count == FCW'(1));
               cbits  <= CB_RUN;
               if (act == A_BEGIN) begin
                  ctl_wr   <= 1'b1;
                  ctl_data <= CB_RUN | CB_START;
                  phase    <= PH_START;
               end else begin
                  rs_pend  <= 1'b1;
                  phase    <= PH_RESTART;
               end
            end
            A_RSTART: begin
               rs_pend  <= 1'b0;
               ctl_wr   <= 1'b1;
               ctl_data <= cbits | CB_START;
            end
            A_ADDR1: begin
               dat_wr   <= 1'b1;
               dat_data <= lead_byte(c_addr, c_ten, c_rd);
               ctl_wr   <= 1'b1;
               ctl_data <= cbits;
               phase    <= PH_ADR1;
            end
            A_ADDR2: begin
               dat_wr   <= 1'b1;
               dat_data <= c_addr[7:0];
               ctl_wr   <= 1'b1;
               ctl_data <= cbits;
               phase    <= PH_ADR2;
            end
            A_SEND: begin
               tx_pend  <= 1'b0;
               dat_wr   <= 1'b1;
               dat_data <= wr_data;
               ctl_wr   <= 1'b1;
               ctl_data <= cbits;
               left     <= left - LEN_W'(1);
               phase    <= PH_WACK;
            end
            A_HOLD: begin
               tx_pend <= 1'b1;
               phase   <= PH_WACK;
            end
            A_CONT: begin
               ctl_wr <= 1'b1;
               if (left == LEN_W'(1)) begin
                  cbits    <= cbits & ~CB_ACK;
                  ctl_data <= cbits & ~CB_ACK;
               end else begin
                  ctl_data <= cbits;
               end
               phase <= PH_RDAT;
            end
            A_RECV: begin
               rd_valid <= 1'b1;
               rd_data  <= rd_reg;
               left     <= left - LEN_W'(1);
               ctl_wr   <= 1'b1;
               if (left == LEN_W'(2)) begin
                  cbits    <= cbits & ~CB_ACK;
                  ctl_data <= cbits & ~CB_ACK;
               end else begin
                  ctl_data <= cbits;
               end
               phase <= PH_RDAT;
            end
            A_RECV_STOP, A_FINISH: begin
               if (act == A_RECV_STOP) begin
                  rd_valid <= 1'b1;
                  rd_data  <= rd_reg;
               end
               ctl_wr   <= 1'b1;
               ctl_data <= stop_bits;
               cbits    <= cbits & ~CB_IEN;
               fin_pend <= 1'b1;
               phase    <= PH_IDLE;
            end
            A_NODEV, A_BUSERR: begin
               ctl_wr    <= 1'b1;
               ctl_data  <= stop_bits;
               cbits     <= CB_RUN;
               err_nodev <= (act == A_NODEV);
               err_bus   <= (act == A_BUSERR);
               ctl_reset <= (act == A_BUSERR);
               phase     <= PH_IDLE;
            end
            A_STRAY: begin
               ctl_wr   <= 1'b1;
               ctl_data <= stop_bits;
            end
            default: ;
         endcase
      end
   end

   assert_start_on_go_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go && !q_empty && !irq) |=> (ctl_wr && ctl_data[5] && busy));
   assert_stop_clears_ien_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_data[4]) |-> (!ctl_data[7] && !ctl_data[5]));
   assert_nodev_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_nodev |-> (ctl_wr && ctl_data[4] && !done && !ctl_reset));
   assert_buserr_resets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_bus |-> (ctl_reset && ctl_wr && ctl_data[4]));
   assert_stray_stop_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && irq) |=> (ctl_wr && ctl_data[4] && !err_nodev && !err_bus && !dat_wr));
   assert_single_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err_nodev, err_bus}));
   assert_read_byte_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tx_pend && !rs_pend && irq && status == SC_RD_NACK)
         |=> (rd_valid && ctl_wr && ctl_data[4]));

endmodule

// File: tb/twi_xfer_seq_test.sv
`timescale 1ns/1ps
module twi_xfer_seq_test;

   localparam int LEN_W = 8;
   localparam int GC    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic desc_valid = 1'b0;
   logic [9:0] desc_addr = '0;
   logic desc_rd = 1'b0, desc_ten = 1'b0;
   logic [LEN_W-1:0] desc_len = '0;
   logic go = 1'b0, irq = 1'b0, wr_valid = 1'b1;
   logic [7:0] status = '0, rd_reg = '0;
   logic desc_ready, busy, ctl_wr, dat_wr, ctl_reset, wr_ready;
   logic rd_valid, done, err_nodev, err_bus;
   logic [7:0] ctl_data, dat_data, rd_data, wr_data;

   logic [7:0] wbytes [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
   int widx = 0;
   int n_chk = 0, n_err = 0;

   assign wr_data = wbytes[widx % 8];

   always #4 clk = ~clk;

   always @(posedge clk) if (wr_ready) widx <= widx + 1;

   twi_xfer_seq #(.LEN_W(LEN_W), .DESC_DEPTH(4), .GUARD_EN(1'b1), .GUARD_CYC(GC)) uut (
      .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_addr(desc_addr), .desc_rd(desc_rd), .desc_ten(desc_ten), .desc_len(desc_len),
      .go(go), .busy(busy), .irq(irq), .status(status), .rd_reg(rd_reg),
      .ctl_wr(ctl_wr), .ctl_data(ctl_data), .dat_wr(dat_wr), .dat_data(dat_data),
      .ctl_reset(ctl_reset), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err_nodev(err_nodev),
      .err_bus(err_bus)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [9:0] a, input logic rd, input logic ten, input int len);
      desc_valid = 1'b1; desc_addr = a; desc_rd = rd; desc_ten = ten; desc_len = LEN_W'(len);
      @(negedge clk);
      desc_valid = 1'b0;
   endtask

   task automatic pulse_go();
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
   endtask

   task automatic event_in(input logic [7:0] st, input logic [7:0] rb);
      irq = 1'b1; status = st; rd_reg = rb;
      @(negedge clk);
      irq = 1'b0;
   endtask

   // counts falling edges until done is seen; STOP was observed at the current edge
   task automatic expect_done(input string tag);
      int n = 0;
      while (!done && n < 40) begin
         @(negedge clk);
         n++;
      end
      chk(tag, n, GC);
      @(negedge clk);
      chk({tag, " busy released"}, busy, 0);
   endtask

   task automatic t_reset();
      chk("R1 reset busy", busy, 0);
      chk("R1 reset ctl_wr", ctl_wr, 0);
      chk("R12 reset done", done, 0);
   endtask

   task automatic t_write7();
      push(10'h050, 1'b0, 1'b0, 2);
      pulse_go();
      chk("R1 start ctl", {ctl_wr, ctl_data}, 9'h1E4);
      chk("R1 busy", busy, 1);
      event_in(8'h08, 8'h00);
      chk("R2 addr byte", {dat_wr, dat_data}, 9'h1A0);
      chk("R2 ctl run", {ctl_wr, ctl_data}, 9'h1C4);
      push(10'h070, 1'b0, 1'b0, 1);
      pulse_go();
      chk("R12 go ignored while busy", ctl_wr, 0);
      event_in(8'h18, 8'h00);
      chk("R4 first data", {dat_wr, dat_data}, 9'h111);
      event_in(8'h28, 8'h00);
      chk("R4 second data", {dat_wr, dat_data}, 9'h122);
      event_in(8'h28, 8'h00);
      chk("R5 final stop", {ctl_wr, ctl_data}, 9'h154);
      chk("R5 no data write", dat_wr, 0);
      expect_done("R12 done delay");
      pulse_go();
      chk("R13 flushed go ctl", ctl_wr, 0);
      chk("R13 flushed go busy", busy, 0);
   endtask

   task automatic t_chain();
      int n = 0;
      push(10'h022, 1'b0, 1'b0, 1);
      push(10'h033, 1'b1, 1'b0, 2);
      pulse_go();
      event_in(8'h08, 8'h00);
      chk("R2 chain addr", dat_data, 8'h44);
      event_in(8'h18, 8'h00);
      chk("R4 chain data", {dat_wr, dat_data}, 9'h133);
      event_in(8'h28, 8'h00);
      chk("R6 no stop at restart decision", ctl_wr, 0);
      while (!ctl_wr && n < 40) begin
         @(negedge clk);
         n++;
      end
      chk("R6 restart delay", n, GC);
      chk("R6 restart ctl", ctl_data, 8'hE4);
      event_in(8'h10, 8'h00);
      chk("R2 read addr byte", {dat_wr, dat_data}, 9'h167);
      event_in(8'h40, 8'h00);
      chk("R7 ack held", {ctl_wr, ctl_data}, 9'h1C4);
      event_in(8'h50, 8'h9A);
      chk("R8 first read byte", {rd_valid, rd_data}, 9'h19A);
      chk("R7 ack dropped", {ctl_wr, ctl_data}, 9'h1C0);
      event_in(8'h58, 8'h5B);
      chk("R8 last read byte", {rd_valid, rd_data}, 9'h15B);
      chk("R8 read stop", {ctl_wr, ctl_data}, 9'h150);
      expect_done("R12 read done delay");
   endtask

   task automatic t_ten_write();
      push(10'h2B5, 1'b0, 1'b1, 1);
      pulse_go();
      event_in(8'h08, 8'h00);
      chk("R3 ten lead write", dat_data, 8'hF4);
      event_in(8'h18, 8'h00);
      chk("R3 ten second", {dat_wr, dat_data}, 9'h1B5);
      event_in(8'hD0, 8'h00);
      chk("R4 after second ack", {dat_wr, dat_data}, 9'h144);
      event_in(8'h28, 8'h00);
      chk("R5 ten stop", {ctl_wr, ctl_data}, 9'h154);
      expect_done("R12 ten done");
   endtask

   task automatic t_ten_read();
      push(10'h2B5, 1'b1, 1'b1, 1);
      pulse_go();
      event_in(8'h08, 8'h00);
      chk("R3 ten lead read", dat_data, 8'hF5);
      event_in(8'h40, 8'h00);
      chk("R3 ten second on 40", {dat_wr, dat_data}, 9'h1B5);
      event_in(8'hE0, 8'h00);
      chk("R7 single byte ack off", {ctl_wr, ctl_data}, 9'h1C0);
      event_in(8'h58, 8'h77);
      chk("R8 ten read byte", {rd_valid, rd_data}, 9'h177);
      expect_done("R12 ten read done");
   endtask

   task automatic t_zero_read();
      push(10'h010, 1'b1, 1'b0, 0);
      pulse_go();
      event_in(8'h08, 8'h00);
      chk("R2 zero read addr", dat_data, 8'h21);
      event_in(8'h40, 8'h00);
      chk("R7 zero read stop", {ctl_wr, ctl_data}, 9'h154);
      chk("R7 zero read no byte", rd_valid, 0);
      expect_done("R7 zero read done");
   endtask

   task automatic t_nodev();
      push(10'h011, 1'b0, 1'b0, 1);
      push(10'h011, 1'b0, 1'b0, 1);
      pulse_go();
      event_in(8'h08, 8'h00);
      event_in(8'h20, 8'h00);
      chk("R9 stop", ctl_data[4], 1);
      chk("R9 err_nodev", {err_nodev, err_bus, done}, 3'b100);
      chk("R9 idle", busy, 0);
      pulse_go();
      chk("R13 flushed after error", ctl_wr, 0);
   endtask

   task automatic t_buserr();
      push(10'h012, 1'b0, 1'b0, 1);
      pulse_go();
      event_in(8'h08, 8'h00);
      event_in(8'hA5, 8'h00);
      chk("R10 reset and err", {ctl_reset, err_bus, err_nodev}, 3'b110);
      chk("R10 stop", {ctl_wr, ctl_data[4]}, 2'b11);
   endtask

   task automatic t_stray();
      push(10'h013, 1'b0, 1'b0, 0);
      event_in(8'h28, 8'h00);
      chk("R11 stray stop", {ctl_wr, ctl_data[4]}, 2'b11);
      chk("R11 stray no flag", {err_nodev, err_bus, done, dat_wr}, 4'b0000);
      pulse_go();
      chk("R11 descriptor kept", {ctl_wr, ctl_data}, 9'h1E4);
      event_in(8'h08, 8'h00);
      chk("R11 kept addr", dat_data, 8'h26);
      event_in(8'h18, 8'h00);
      chk("R5 empty write stop", {ctl_wr, ctl_data}, 9'h154);
      expect_done("R12 empty write done");
   endtask

   task automatic t_stall();
      push(10'h014, 1'b0, 1'b0, 1);
      pulse_go();
      event_in(8'h08, 8'h00);
      wr_valid = 1'b0;
      event_in(8'h18, 8'h00);
      chk("R4 stall no write", dat_wr, 0);
      @(negedge clk);
      @(negedge clk);
      chk("R4 still stalled", dat_wr, 0);
      wr_valid = 1'b1;
      @(negedge clk);
      chk("R4 write after stall", {dat_wr, dat_data}, 9'h155);
      event_in(8'h28, 8'h00);
      chk("R5 stall stop", {ctl_wr, ctl_data}, 9'h154);
      expect_done("R12 stall done");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write7();
      t_chain();
      t_ten_write();
      t_ten_read();
      t_zero_read();
      t_nodev();
      t_buserr();
      t_stray();
      t_stall();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule